// File: doc/BRIEF.md
# Interleaved SECDED Memory with Background Scrubbing

This block holds a small memory of 64-bit words. Each word is stored with eight check bits as a 72-bit extended Hamming codeword. Seven of the check bits locate and repair any single flipped bit. The eighth is a parity bit over the whole codeword, so a pair of flips is flagged as uncorrectable and is left as it is. Four logical words share one physical row, and their codeword bits alternate across it. A strike that upsets up to four neighbouring cells therefore leaves at most one bad bit in each word, and every such bit can be corrected.

A host port writes and reads words. A read returns corrected data one cycle later with two flags, corrected and uncorrectable, and writes a repaired word back to the array. When enabled, a background engine visits one address of a configured range after each configured gap, repairs any single-bit error it finds, and moves on. It wraps from the top of the range to the bottom. This stops single-bit errors from building up into double-bit errors over time. The host always wins a cycle. A step that finds the host busy stays pending and runs in the next idle cycle. Two saturating counters record corrected events and uncorrectable events. An upset input flips chosen physical cells, so that a particle strike on the array can be modelled.

Top module: `ecc_scrub_mem`

## Requirements
- R1: A host write (`req_i`=1, `we_i`=1) stores the word. A host read (`req_i`=1, `we_i`=0) raises `rvalid_o` on the next cycle with the stored data and with both error flags low.
- R2: If any one of the 72 stored bits of a word is flipped, a host read returns the original data with `rd_corr_o`=1 and `rd_unc_o`=0. The repaired word is written back, so the next read of that word has both flags low.
- R3: If two stored bits of one word are flipped, a host read gives `rd_unc_o`=1 and `rd_corr_o`=0. The word is not repaired, so a repeat read again gives `rd_unc_o`=1.
- R4: Physical bit p of row r holds codeword bit p/4 of logical address 4*r + (p mod 4). An upset of up to 4 adjacent physical bits in one row is corrected in every word it touches.
- R5: With `scrub_en_i`=1 and no host traffic, `scrub_vld_o` pulses once every `scrub_gap_i`+1 cycles. Successive steps show `scrub_addr_o` = lo, lo+1, ..., hi and then wrap to lo.
- R6: A scrub step that finds a single-bit error writes back the corrected word. A second single flip in the same word later is then still correctable.
- R7: In a cycle where a scrub step is due and `req_i`=1, no step happens (`scrub_vld_o`=0). The same address is stepped in the first cycle without `req_i`.
- R8: `corr_cnt_o` and `unc_cnt_o` count corrected and uncorrectable events from host reads and scrub steps. Each stops at 2^CNT_W-1.
- R9: After reset the array is all zero (a valid codeword), the counters are zero, `rvalid_o` is low, and reading any address returns 0 with both flags low.
- R10: With `scrub_en_i`=0, `scrub_vld_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Logical word address |
| wdata_i | input | 64 | Write data |
| rvalid_o | output | 1 | Read result valid (one cycle after request) |
| rdata_o | output | 64 | Corrected read data |
| rd_corr_o | output | 1 | Read found and fixed a single-bit error |
| rd_unc_o | output | 1 | Read found an uncorrectable error |
| scrub_en_i | input | 1 | Enable background scrubbing |
| scrub_gap_i | input | GAP_W | Idle cycles between scrub steps |
| scrub_lo_i | input | ADDR_W | First address of the scrub range |
| scrub_hi_i | input | ADDR_W | Last address of the scrub range |
| scrub_vld_o | output | 1 | A scrub step occurs this cycle |
| scrub_addr_o | output | ADDR_W | Address of the pending or current scrub step |
| upset_i | input | 1 | Apply an upset this cycle |
| upset_row_i | input | ADDR_W-log2(ILV) | Physical row to upset |
| upset_pos_i | input | log2(72*ILV) | First physical bit of the upset |
| upset_pat_i | input | 4 | Which of 4 adjacent bits flip |
| corr_cnt_o | output | CNT_W | Saturating corrected-event count |
| unc_cnt_o | output | CNT_W | Saturating uncorrectable-event count |

## Verification
The bench flips single bits at many codeword positions, including the overall parity bit (position 0) and the highest bit (71). A decoder that mislocates the syndrome would return wrong data or raise the uncorrectable flag. A four-bit burst across one row checks the interleave. A layout that put neighbouring cells in the same word would report an uncorrectable error there instead of four corrections. A scrub pass followed by a second flip in the same word shows that the repair was actually written back. Without the write-back, the word would read as uncorrectable. The bench also checks the wrap order of the range, the pending step that a host access postpones (a design that dropped it would skip an address), and the saturation of the uncorrectable counter (a design that wrapped would show a small count).

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;
  localparam int DW = 64;
  localparam int CW = 72;
  localparam int PW = 7;

  typedef struct packed {
    logic [DW-1:0] data;
    logic [CW-1:0] cw;
    logic          corr;
    logic          unc;
  } dec_t;

  function automatic logic is_chk_pos(int i);
    return (i & (i - 1)) == 0;
  endfunction

  // bit 0: overall parity, powers of two: check bits, rest: data in ascending order
  function automatic logic [CW-1:0] ecc_enc(logic [DW-1:0] d);
    logic [CW-1:0] cw;
    int k;
    cw = '0;
    k  = 0;
    for (int i = 1; i < CW; i++) begin
      if (!is_chk_pos(i)) begin
        cw[i] = d[k];
        k++;
      end
    end
    for (int b = 0; b < PW; b++) begin
      logic p;
      p = 1'b0;
      for (int i = 1; i < CW; i++)
        if (((i >> b) & 1) == 1) p = p ^ cw[i];
      cw[1 << b] = p;
    end
    cw[0] = ^cw[CW-1:1];
    return cw;
  endfunction

  function automatic dec_t ecc_dec(logic [CW-1:0] cw);
    dec_t r;
    logic [PW-1:0] syn;
    int k;
    syn = '0;
    for (int i = 1; i < CW; i++)
      if (cw[i]) syn = syn ^ PW'(i);
    r.cw   = cw;
    r.corr = 1'b0;
    r.unc  = 1'b0;
    if (^cw) begin
      if (int'(syn) < CW) begin
        r.cw[syn] = ~r.cw[syn];
        r.corr    = 1'b1;
      end else begin
        r.unc = 1'b1;
      end
    end else if (syn != '0) begin
      r.unc = 1'b1;
    end
    r.data = '0;
    k = 0;
    for (int i = 1; i < CW; i++) begin
      if (!is_chk_pos(i)) begin
        r.data[k] = r.cw[i];
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_sat_cnt.sv
module ecc_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && ~&cnt_o)     cnt_o <= cnt_o + 1'b1;
  end

  // R8
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_o) |=> (&cnt_o));
  // R8
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/ecc_scrub_ctrl.sv
module ecc_scrub_ctrl #(
  parameter int ADDR_W = 6,
  parameter int GAP_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [GAP_W-1:0]  gap_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic              host_req_i,
  output logic              step_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [GAP_W-1:0]  gap_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              due;

  assign due    = en_i && (gap_q >= gap_i);
  assign step_o = due && !host_req_i;
  assign addr_o = (ptr_q < lo_i || ptr_q > hi_i) ? lo_i : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      ptr_q <= '0;
    end else begin
      if (!en_i || step_o) gap_q <= '0;
      else if (!due)       gap_q <= gap_q + 1'b1;
      if (step_o) ptr_q <= (addr_o >= hi_i) ? lo_i : addr_o + 1'b1;
    end
  end

  // R7
  host_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (due && host_req_i) |=> $stable(ptr_q));
  // R5
  gap_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && gap_i != '0) |=> !step_o);
  // R10
  idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !step_o);
endmodule

// File: rtl/ecc_ilv_array.sv
module ecc_ilv_array #(
  parameter int ROWS  = 16,
  parameter int ILV   = 4,
  parameter int CW    = 72,
  parameter int BURST = 4,
  localparam int ROW_AW = $clog2(ROWS),
  localparam int LANE_W = $clog2(ILV),
  localparam int ROW_W  = CW * ILV,
  localparam int POS_W  = $clog2(ROW_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ROW_AW-1:0] rd_row_i,
  input  logic [LANE_W-1:0] rd_lane_i,
  output logic [CW-1:0]     rd_cw_o,
  input  logic              wr_en_i,
  input  logic [CW-1:0]     wr_cw_i,
  input  logic              up_en_i,
  input  logic [ROW_AW-1:0] up_row_i,
  input  logic [POS_W-1:0]  up_pos_i,
  input  logic [BURST-1:0]  up_pat_i
);
  logic [ROW_W-1:0] mem_q [ROWS];
  logic [ROW_W-1:0] mem_d [ROWS];

  // codeword bit c of lane l sits at physical bit c*ILV + l
  always_comb begin
    for (int c = 0; c < CW; c++)
      rd_cw_o[c] = mem_q[rd_row_i][c*ILV + int'(rd_lane_i)];
  end

  // write-back always targets the row/lane just read
  always_comb begin
    mem_d = mem_q;
    if (wr_en_i)
      for (int c = 0; c < CW; c++)
        mem_d[rd_row_i][c*ILV + int'(rd_lane_i)] = wr_cw_i[c];
    if (up_en_i)
      for (int j = 0; j < BURST; j++)
        if (up_pat_i[j] && (int'(up_pos_i) + j < ROW_W))
          mem_d[up_row_i][int'(up_pos_i) + j] = ~mem_d[up_row_i][int'(up_pos_i) + j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '{default: '0};
    else         mem_q <= mem_d;
  end
endmodule

// File: rtl/ecc_scrub_mem.sv
module ecc_scrub_mem
  import ecc_scrub_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int ILV    = 4,
  parameter int GAP_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               req_i,
  input  logic                               we_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [63:0]                        wdata_i,
  output logic                               rvalid_o,
  output logic [63:0]                        rdata_o,
  output logic                               rd_corr_o,
  output logic                               rd_unc_o,
  input  logic                               scrub_en_i,
  input  logic [GAP_W-1:0]                   scrub_gap_i,
  input  logic [ADDR_W-1:0]                  scrub_lo_i,
  input  logic [ADDR_W-1:0]                  scrub_hi_i,
  output logic                               scrub_vld_o,
  output logic [ADDR_W-1:0]                  scrub_addr_o,
  input  logic                               upset_i,
  input  logic [ADDR_W-$clog2(ILV)-1:0]      upset_row_i,
  input  logic [$clog2(72*ILV)-1:0]          upset_pos_i,
  input  logic [3:0]                         upset_pat_i,
  output logic [CNT_W-1:0]                   corr_cnt_o,
  output logic [CNT_W-1:0]                   unc_cnt_o
);
  localparam int LANE_W = $clog2(ILV);
  localparam int ROWS   = (2 ** ADDR_W) / ILV;

  logic              host_rd, host_wr, chk_op;
  logic [ADDR_W-1:0] op_addr;
  logic [CW-1:0]     rd_cw, wr_cw;
  logic              wr_en;
  dec_t              dec;

  ecc_scrub_ctrl #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_ctrl (
    .clk_i, .rst_ni,
    .en_i       (scrub_en_i),
    .gap_i      (scrub_gap_i),
    .lo_i       (scrub_lo_i),
    .hi_i       (scrub_hi_i),
    .host_req_i (req_i),
    .step_o     (scrub_vld_o),
    .addr_o     (scrub_addr_o)
  );

  assign host_rd = req_i && !we_i;
  assign host_wr = req_i && we_i;
  assign chk_op  = host_rd || scrub_vld_o;
  assign op_addr = req_i ? addr_i : scrub_addr_o;
  assign dec     = ecc_dec(rd_cw);
  assign wr_en   = host_wr || (chk_op && dec.corr);
  assign wr_cw   = host_wr ? ecc_enc(wdata_i) : dec.cw;

  ecc_ilv_array #(.ROWS(ROWS), .ILV(ILV), .CW(CW), .BURST(4)) u_arr (
    .clk_i, .rst_ni,
    .rd_row_i  (op_addr[ADDR_W-1:LANE_W]),
    .rd_lane_i (op_addr[LANE_W-1:0]),
    .rd_cw_o   (rd_cw),
    .wr_en_i   (wr_en),
    .wr_cw_i   (wr_cw),
    .up_en_i   (upset_i),
    .up_row_i  (upset_row_i),
    .up_pos_i  (upset_pos_i),
    .up_pat_i  (upset_pat_i)
  );

  ecc_sat_cnt #(.W(CNT_W)) u_corr_cnt (
    .clk_i, .rst_ni, .inc_i(chk_op && dec.corr), .cnt_o(corr_cnt_o));
  ecc_sat_cnt #(.W(CNT_W)) u_unc_cnt (
    .clk_i, .rst_ni, .inc_i(chk_op && dec.unc), .cnt_o(unc_cnt_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o  <= 1'b0;
      rdata_o   <= '0;
      rd_corr_o <= 1'b0;
      rd_unc_o  <= 1'b0;
    end else begin
      rvalid_o  <= host_rd;
      rd_corr_o <= host_rd && dec.corr;
      rd_unc_o  <= host_rd && dec.unc;
      if (host_rd) rdata_o <= dec.data;
    end
  end

  // R1
  rd_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd |=> rvalid_o);
  // R3
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_corr_o && rd_unc_o));
  // R7
  host_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> !scrub_vld_o);
  // R3
  no_unc_fix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_op && dec.unc && !host_wr) |-> !wr_en);
endmodule

// File: tb/ecc_scrub_mem_tb.sv
module ecc_scrub_mem_tb;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 4;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 0, we_i = 0;
  logic [5:0]  addr_i = '0;
  logic [63:0] wdata_i = '0;
  logic        rvalid_o, rd_corr_o, rd_unc_o;
  logic [63:0] rdata_o;
  logic        scrub_en_i = 0;
  logic [15:0] scrub_gap_i = '0;
  logic [5:0]  scrub_lo_i = '0, scrub_hi_i = '0;
  logic        scrub_vld_o;
  logic [5:0]  scrub_addr_o;
  logic        upset_i = 0;
  logic [3:0]  upset_row_i = '0;
  logic [8:0]  upset_pos_i = '0;
  logic [3:0]  upset_pat_i = '0;
  logic [CNT_W-1:0] corr_cnt_o, unc_cnt_o;

  int total = 0, bad = 0, exp_corr = 0;

  always #5 clk_i = ~clk_i;

  ecc_scrub_mem #(.ADDR_W(ADDR_W), .ILV(4), .GAP_W(16), .CNT_W(CNT_W)) u_dut (.*);

  // {addr, codeword bit to flip, data}
  localparam logic [76:0] VEC [8] = '{
    {6'd0,  7'd0,  64'h0123_4567_89ab_cdef},
    {6'd1,  7'd1,  64'hffff_ffff_ffff_ffff},
    {6'd2,  7'd2,  64'h8000_0000_0000_0001},
    {6'd3,  7'd3,  64'hdead_beef_cafe_f00d},
    {6'd17, 7'd37, 64'h5555_aaaa_5555_aaaa},
    {6'd33, 7'd64, 64'h0000_0000_0000_0000},
    {6'd46, 7'd71, 64'h1357_9bdf_0246_8ace},
    {6'd63, 7'd50, 64'hfedc_ba98_7654_3210}
  };

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1; req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [5:0] a);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    @(posedge clk_i); #1; req_i = 0;
  endtask

  task automatic hit(input logic [3:0] row, input int pos, input logic [3:0] pat);
    @(negedge clk_i); upset_i = 1; upset_row_i = row; upset_pos_i = 9'(pos); upset_pat_i = pat;
    @(posedge clk_i); #1; upset_i = 0;
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int stp_addr [5];
    int stp_cyc  [5];
    int ns, nv;
    logic [5:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R9 reset state
    chk(rvalid_o == 0 && corr_cnt_o == 0 && unc_cnt_o == 0, "R9 reset outs", {rvalid_o, corr_cnt_o, unc_cnt_o}, 0);
    rd(6'd40);
    chk(rvalid_o && rdata_o == 0 && !rd_corr_o && !rd_unc_o, "R9 zero read", rdata_o, 0);

    // R1 vector table: write all, read clean
    for (int i = 0; i < 8; i++) wr(VEC[i][76:71], VEC[i][63:0]);
    for (int i = 0; i < 8; i++) begin
      rd(VEC[i][76:71]);
      chk(rvalid_o && rdata_o == VEC[i][63:0] && !rd_corr_o && !rd_unc_o, "R1 clean read", rdata_o, VEC[i][63:0]);
    end

    // R2 single flips at listed codeword bits, then re-read clean
    for (int i = 0; i < 8; i++) begin
      logic [5:0] a;
      a = VEC[i][76:71];
      hit(a[5:2], int'(VEC[i][70:64]) * 4 + int'(a[1:0]), 4'b0001);
      rd(a);
      exp_corr++;
      chk(rdata_o == VEC[i][63:0] && rd_corr_o && !rd_unc_o, "R2 corrected read", rdata_o, VEC[i][63:0]);
      rd(a);
      chk(rdata_o == VEC[i][63:0] && !rd_corr_o && !rd_unc_o, "R2 written back", {rd_corr_o, rd_unc_o}, 0);
    end
    chk(corr_cnt_o == 4'(exp_corr), "R8 corr count", corr_cnt_o, exp_corr);

    // R4 burst over 4 adjacent cells of row 2 (addr 8..11)
    for (int l = 0; l < 4; l++) wr(6'(8 + l), 64'h1111_0000_0000_0000 * (l + 1) + 64'(l));
    hit(4'd2, 40, 4'b1111);
    for (int l = 0; l < 4; l++) begin
      rd(6'(8 + l));
      exp_corr++;
      chk(rdata_o == 64'h1111_0000_0000_0000 * (l + 1) + 64'(l) && rd_corr_o && !rd_unc_o,
          "R4 burst lane", rdata_o, 64'h1111_0000_0000_0000 * (l + 1) + 64'(l));
    end

    // R3 double flip in addr 12 (row 3 lane 0, codeword bits 0 and 5)
    wr(6'd12, 64'h0f0f_0f0f_0f0f_0f0f);
    hit(4'd3, 0, 4'b0001);
    hit(4'd3, 20, 4'b0001);
    rd(6'd12);
    chk(rd_unc_o && !rd_corr_o, "R3 double detect", {rd_corr_o, rd_unc_o}, 2'b01);
    rd(6'd12);
    chk(rd_unc_o && !rd_corr_o, "R3 not repaired", {rd_corr_o, rd_unc_o}, 2'b01);
    for (int i = 0; i < 14; i++) rd(6'd12);
    chk(unc_cnt_o == 4'hf, "R8 unc saturate", unc_cnt_o, 4'hf);
    chk(corr_cnt_o == 4'(exp_corr), "R8 corr unchanged", corr_cnt_o, exp_corr);

    // R10 disabled scrub
    nv = 0;
    scrub_lo_i = 6'd4; scrub_hi_i = 6'd7; scrub_gap_i = 16'd3;
    for (int c = 0; c < 20; c++) begin @(negedge clk_i); if (scrub_vld_o) nv++; end
    chk(nv == 0, "R10 no steps", nv, 0);

    // R5 order, spacing and wrap
    @(negedge clk_i); scrub_en_i = 1;
    ns = 0;
    for (int c = 0; c < 60 && ns < 5; c++) begin
      @(negedge clk_i);
      if (scrub_vld_o) begin stp_addr[ns] = int'(scrub_addr_o); stp_cyc[ns] = c; ns++; end
    end
    chk(ns == 5, "R5 step count", ns, 5);
    for (int i = 0; i < 5; i++)
      chk(stp_addr[i] == 4 + (i % 4), "R5 step addr", stp_addr[i], 4 + (i % 4));
    for (int i = 1; i < 5; i++)
      chk(stp_cyc[i] - stp_cyc[i-1] == 4, "R5 spacing", stp_cyc[i] - stp_cyc[i-1], 4);

    // R7 host access while a step is due
    while (!scrub_vld_o) @(negedge clk_i);
    held = scrub_addr_o;
    req_i = 1; we_i = 0; addr_i = 6'd0;
    #1;
    chk(!scrub_vld_o, "R7 host wins", scrub_vld_o, 0);
    @(posedge clk_i); #1; req_i = 0;
    chk(rvalid_o && rdata_o == VEC[0][63:0], "R7 host read", rdata_o, VEC[0][63:0]);
    @(negedge clk_i);
    chk(scrub_vld_o && scrub_addr_o == held, "R7 retried step", scrub_addr_o, held);
    scrub_en_i = 0;

    // R6 scrub repairs addr 5 (row 1 lane 1, bit 10)
    wr(6'd5, 64'h2468_ace0_1357_9bdf);
    hit(4'd1, 10 * 4 + 1, 4'b0001);
    scrub_lo_i = 6'd0; scrub_hi_i = 6'd15; scrub_gap_i = 16'd0;
    @(negedge clk_i); scrub_en_i = 1;
    repeat (40) @(negedge clk_i);
    scrub_en_i = 0;
    exp_corr++;
    chk(corr_cnt_o == 4'(exp_corr), "R6 scrub corr count", corr_cnt_o, exp_corr);
    hit(4'd1, 30 * 4 + 1, 4'b0001);
    rd(6'd5);
    exp_corr++;
    chk(rdata_o == 64'h2468_ace0_1357_9bdf && rd_corr_o && !rd_unc_o, "R6 second flip ok", rdata_o, 64'h2468_ace0_1357_9bdf);
    chk(corr_cnt_o == 4'(exp_corr), "R8 final corr", corr_cnt_o, exp_corr);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule